// File: doc/BRIEF.md
# Four-Line Round-Robin Transmit Scanner

This block is the transmit side of a controller that multiplexes four serial lines through one register window. Software enables the lines that have bytes waiting by writing one bit per line into a transmit-enable register. Each pulse on the scan tick input makes the block search the lines in rotating order for an enabled one. When it finds a line, it raises transmit-ready, shows the line number in the status word and can interrupt the processor. Software then writes one byte into the shared transmit data register. The byte leaves on a valid/ready stream tagged with the selected line, and transmit-ready drops until a later tick picks the next line.

The status word also carries the receive-done handshake of the companion receive path. That path presents its oldest character on the receive inputs. A tick that finds nothing to transmit raises receive-done, so transmit and receive never become pending on the same tick. Reading the receive buffer returns the presented character and pops it. One interrupt line is the OR of the two enabled conditions. Bit-level serialisation, baud timing and modem control lie outside the block.

Top module: `txscan_mux`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x8020, meaning transmit-ready bit 15 and scan enable bit 5 are set and everything else is clear. The enable register (offset 0x10) reads 0, irq is low and tx_valid is low.
- R2: A scan tick runs the search only when scan enable is 1, transmit-ready is 0 and no byte is held on the output. The search tries the lines in the order last+1, last+2 and so on, modulo 4, where last is the value in status bits 9:8. It selects the first line whose enable bit (enable register bit n for line n) is set. From the next cycle, transmit-ready is 1 and bits 9:8 hold the selected line. If no line is enabled, transmit-ready stays 0 and bits 9:8 keep their value.
- R3: A write to the enable register stores all 16 bits, which read back unchanged, and clears transmit-ready.
- R4: A write to offset 0x18 while transmit-ready is 1 presents wdata[7:0] on tx_data and status bits 9:8 on tx_line, with tx_valid high from the next cycle. It also clears transmit-ready. The byte stays valid and unchanged until tx_ready is high at a clock edge.
- R5: A write to offset 0x18 while transmit-ready is 0 is ignored, and tx_valid stays low.
- R6: A status write changes only transmit interrupt enable (bit 14), receive interrupt enable (bit 6), scan enable (bit 5), clear (bit 4) and maintenance (bit 3). Every access clears the clear bit, so a status read always returns bit 4 as 0.
- R7: A status write with bit 5 at 0 clears transmit-ready and receive-done. While scan enable is 0, ticks change nothing.
- R8: irq equals (transmit-ready AND bit 14) OR (receive-done AND bit 6).
- R9: A tick with scan enable set that selects no line sets receive-done (bit 7) to rx_valid. A tick that selects a line leaves receive-done at 0. A read of offset 0x08 returns {rx_valid at bit 15, rx_line at bits 9:8, rx_char at bits 7:0}, pulses rx_pop if rx_valid is set and clears receive-done.
- R10: A read of offset 0x18 returns 0x0303, the fixed modem status: carrier and data-set-ready for line 2 in bits 0 and 1, and for line 3 in bits 8 and 9.
- R11: While a byte waits on the output (tx_valid high, tx_ready low), a tick does not raise transmit-ready.
- R12: A write to offset 0x08 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| scan_tick | input | 1 | Scan tick, one cycle per scan |
| rx_valid | input | 1 | Receive path has a character |
| rx_char | input | 8 | Oldest received character |
| rx_line | input | 2 | Line of that character |
| rx_pop | output | 1 | Receive character consumed |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Outgoing byte |
| tx_line | output | 2 | Line the byte belongs to |
| irq | output | 1 | Level interrupt request |

## Verification
Read data and rx_pop are combinational, so they are valid in the same cycle as the access. The bench drives every access and tick at a falling edge and samples read data one nanosecond later, before the rising edge. Writes, ticks and output handshakes take effect at the next rising edge. Their results, such as transmit-ready, the line field, receive-done, tx_valid and irq, are therefore checked at the falling edge after that edge or through a later read. Each tick and access is one cycle long with an idle cycle after it, so no check depends on two events sharing an edge.

// File: rtl/txscan_pkg.sv
package txscan_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned CHAR_W  = 8;

  // Register byte offsets
  localparam logic [4:0] OFS_STAT = 5'h00;
  localparam logic [4:0] OFS_RBUF = 5'h08;
  localparam logic [4:0] OFS_TEN  = 5'h10;
  localparam logic [4:0] OFS_TDAT = 5'h18;

  // Status word bit positions
  localparam int unsigned B_MAINT = 3;
  localparam int unsigned B_CLR   = 4;
  localparam int unsigned B_SCAN  = 5;
  localparam int unsigned B_RIE   = 6;
  localparam int unsigned B_RDONE = 7;
  localparam int unsigned B_LINE  = 8;
  localparam int unsigned B_TIE   = 14;
  localparam int unsigned B_TRDY  = 15;

  // Receive buffer valid flag
  localparam int unsigned B_RXV   = 15;

  // Fixed modem status word
  localparam logic [REG_W-1:0] MODEM_WORD = 16'h0303;

  typedef struct packed {
    logic any;
    logic stat_wr;
    logic ten_wr;
    logic tdat_wr;
    logic rbuf_rd;
  } acc_t;
endpackage

// File: rtl/txscan_decode.sv
module txscan_decode
  import txscan_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  logic hit_stat, hit_rbuf, hit_ten, hit_tdat;

  always_comb begin
    hit_stat = (addr == ADDR_W'(OFS_STAT));
    hit_rbuf = (addr == ADDR_W'(OFS_RBUF));
    hit_ten  = (addr == ADDR_W'(OFS_TEN));
    hit_tdat = (addr == ADDR_W'(OFS_TDAT));
    acc.any     = sel;
    acc.stat_wr = sel &&  wr && hit_stat;
    acc.ten_wr  = sel &&  wr && hit_ten;
    acc.tdat_wr = sel &&  wr && hit_tdat;
    acc.rbuf_rd = sel && !wr && hit_rbuf;
  end
endmodule

// File: rtl/txscan_pick.sv
module txscan_pick #(
  parameter int unsigned LINES = 4,
  localparam int unsigned LW   = $clog2(LINES)
) (
  input  logic [LINES-1:0] en,
  input  logic [LW-1:0]    last,
  output logic             found,
  output logic [LW-1:0]    pick
);
  logic [LW-1:0]    cand_idx [LINES];
  logic [LINES-1:0] cand_hit;

  // Candidate k is the line k+1 steps after the last selection
  for (genvar k = 0; k < LINES; k++) begin : g_cand
    assign cand_idx[k] = last + LW'(k + 1);
    assign cand_hit[k] = en[cand_idx[k]];
  end

  always_comb begin
    found = |cand_hit;
    pick  = last;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (cand_hit[k]) pick = cand_idx[k];
    end
  end
endmodule

// File: rtl/txscan_txout.sv
module txscan_txout #(
  parameter int unsigned CW = 8,
  parameter int unsigned LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_data,
  input  logic [LW-1:0] ld_line,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [CW-1:0] out_data,
  output logic [LW-1:0] out_line
);
  logic          valid_q, valid_d;
  logic [CW-1:0] data_q;
  logic [LW-1:0] line_q;

  always_comb begin
    valid_d = valid_q && !out_ready;
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      line_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        data_q <= ld_data;
        line_q <= ld_line;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_line  = line_q;
endmodule

// File: rtl/txscan_mux.sv
module txscan_mux
  import txscan_pkg::*;
#(
  parameter int unsigned LINES  = 4,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              scan_tick,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [LW-1:0]     rx_line,
  output logic              rx_pop,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic [LW-1:0]     tx_line,
  output logic              irq
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_t acc;

  txscan_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel (bus_sel),
    .wr  (bus_wr),
    .addr(bus_addr),
    .acc (acc)
  );

  // Status and enable state
  logic             tie_q, rie_q, scan_q, clr_q, maint_q, rdone_q, trdy_q;
  logic [LW-1:0]    line_q;
  logic [REG_W-1:0] ten_q;

  // After the register access
  logic             a_tie, a_rie, a_scan, a_clr, a_maint, a_rdone, a_trdy;
  logic [REG_W-1:0] a_ten;

  // After the scan tick
  logic             rdone_d, trdy_d;
  logic [LW-1:0]    line_d;

  logic             tx_load, tx_hold, scan_go;
  logic             pick_found;
  logic [LW-1:0]    pick_line;

  assign tx_load = acc.tdat_wr && trdy_q;
  assign tx_hold = (tx_valid && !tx_ready) || tx_load;

  always_comb begin
    a_tie   = tie_q;
    a_rie   = rie_q;
    a_scan  = scan_q;
    a_clr   = clr_q;
    a_maint = maint_q;
    a_rdone = rdone_q;
    a_trdy  = trdy_q;
    a_ten   = ten_q;
    if (acc.any) a_clr = 1'b0;
    if (acc.stat_wr) begin
      a_tie   = bus_wdata[B_TIE];
      a_rie   = bus_wdata[B_RIE];
      a_scan  = bus_wdata[B_SCAN];
      a_clr   = bus_wdata[B_CLR];
      a_maint = bus_wdata[B_MAINT];
      if (!bus_wdata[B_SCAN]) begin
        a_trdy  = 1'b0;
        a_rdone = 1'b0;
      end
    end
    if (acc.ten_wr) begin
      a_ten  = bus_wdata;
      a_trdy = 1'b0;
    end
    if (tx_load)     a_trdy  = 1'b0;
    if (acc.rbuf_rd) a_rdone = 1'b0;
  end

  txscan_pick #(.LINES(LINES)) u_pick (
    .en   (a_ten[LINES-1:0]),
    .last (line_q),
    .found(pick_found),
    .pick (pick_line)
  );

  assign scan_go = a_scan && !a_trdy && !tx_hold;

  always_comb begin
    rdone_d = a_rdone;
    trdy_d  = a_trdy;
    line_d  = line_q;
    if (scan_tick) begin
      if (scan_go && pick_found) begin
        trdy_d  = 1'b1;
        line_d  = pick_line;
        rdone_d = 1'b0;
      end else begin
        rdone_d = rx_valid && a_scan;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tie_q   <= 1'b0;
      rie_q   <= 1'b0;
      scan_q  <= 1'b1;
      clr_q   <= 1'b0;
      maint_q <= 1'b0;
      rdone_q <= 1'b0;
      trdy_q  <= 1'b1;
      line_q  <= '0;
      ten_q   <= '0;
    end else begin
      tie_q   <= a_tie;
      rie_q   <= a_rie;
      scan_q  <= a_scan;
      clr_q   <= a_clr;
      maint_q <= a_maint;
      rdone_q <= rdone_d;
      trdy_q  <= trdy_d;
      line_q  <= line_d;
      if (acc.ten_wr) ten_q <= a_ten;
    end
  end

  txscan_txout #(.CW(CHAR_W), .LW(LW)) u_txout (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tx_load),
    .ld_data  (bus_wdata[CHAR_W-1:0]),
    .ld_line  (line_q),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .out_line (tx_line)
  );

  // Read path
  logic [REG_W-1:0] stat_view, rbuf_view;

  always_comb begin
    stat_view               = '0;
    stat_view[B_TRDY]       = trdy_q;
    stat_view[B_TIE]        = tie_q;
    stat_view[B_LINE +: LW] = line_q;
    stat_view[B_RDONE]      = rdone_q;
    stat_view[B_RIE]        = rie_q;
    stat_view[B_SCAN]       = scan_q;
    stat_view[B_CLR]        = clr_q && !acc.any;
    stat_view[B_MAINT]      = maint_q;

    rbuf_view               = '0;
    rbuf_view[B_RXV]        = rx_valid;
    rbuf_view[B_LINE +: LW] = rx_line;
    rbuf_view[CHAR_W-1:0]   = rx_char;

    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if      (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = stat_view;
      else if (bus_addr == ADDR_W'(OFS_RBUF)) bus_rdata = rbuf_view;
      else if (bus_addr == ADDR_W'(OFS_TEN))  bus_rdata = ten_q;
      else if (bus_addr == ADDR_W'(OFS_TDAT)) bus_rdata = MODEM_WORD;
    end
  end

  assign rx_pop = acc.rbuf_rd && rx_valid;
  assign irq    = (trdy_q && tie_q) || (rdone_q && rie_q);
endmodule

// File: rtl/txscan_mux_chk.sv
module txscan_mux_chk
  import txscan_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              scan_tick,
  input logic              trdy,
  input logic              tie,
  input logic              rdone,
  input logic              irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [CHAR_W-1:0] tx_data,
  input logic [LW-1:0]     tx_line
);
  logic wr_stat, wr_ten, wr_tdat;
  assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ten  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_TEN));
  assign wr_tdat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_TDAT));

  assert_trdy_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy) |-> $past(scan_tick));

  assert_ten_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ten && !scan_tick) |=> !trdy);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_line)));

  assert_tx_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(wr_tdat && trdy));

  assert_scan_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[B_SCAN]) |=> (!trdy && !rdone));

  assert_irq_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trdy) && tie) |-> irq);

  assert_no_joint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(trdy) && $rose(rdone)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !trdy) |=> !trdy);
endmodule

bind txscan_mux txscan_mux_chk #(.ADDR_W(ADDR_W), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .scan_tick(scan_tick),
  .trdy     (trdy_q),
  .tie      (tie_q),
  .rdone    (rdone_q),
  .irq      (irq),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_line  (tx_line)
);

// File: tb/txscan_mux_test.sv
module txscan_mux_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        scan_tick;
  logic        rx_valid;
  logic [7:0]  rx_char;
  logic [1:0]  rx_line;
  logic        rx_pop;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic [1:0]  tx_line;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int pops   = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  txscan_mux uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scan_tick(scan_tick),
    .rx_valid(rx_valid), .rx_char(rx_char), .rx_line(rx_line), .rx_pop(rx_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_line(tx_line),
    .irq(irq)
  );

  always @(posedge clk) if (rx_pop) pops++;

  // {enables[3:0], found, line[1:0], byte[7:0]}
  localparam logic [14:0] VEC [9] = '{
    {4'hF, 1'b1, 2'd1, 8'h11},
    {4'hF, 1'b1, 2'd2, 8'h22},
    {4'h1, 1'b1, 2'd0, 8'h33},
    {4'h8, 1'b1, 2'd3, 8'h44},
    {4'h8, 1'b1, 2'd3, 8'h5A},
    {4'h6, 1'b1, 2'd1, 8'h66},
    {4'h4, 1'b1, 2'd2, 8'h77},
    {4'h0, 1'b0, 2'd2, 8'h00},
    {4'h3, 1'b1, 2'd0, 8'h99}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    scan_tick = 1'b0; rx_valid = 1'b0; rx_char = '0; rx_line = '0;
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(5'h00, rd); check("R1 status", rd, 16'h8020);
    bus_read(5'h10, rd); check("R1 enables", rd, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 tx_valid", tx_valid, 1'b0);

    // Enable transmit interrupt, keep scanning on
    bus_write(5'h00, 16'h4020);
    check("R8 irq ready+tie", irq, 1'b1);

    // Vector walk: R2 R3 R4 R8
    for (int i = 0; i < 9; i++) begin
      bus_write(5'h10, {12'h000, VEC[i][14:11]});
      check("R3 enable write drops irq", irq, 1'b0);
      bus_read(5'h10, rd); check("R3 enable readback", rd, {12'h000, VEC[i][14:11]});
      tick();
      bus_read(5'h00, rd);
      check("R2 ready after scan", rd[15], VEC[i][10]);
      check("R2 selected line", rd[9:8], VEC[i][9:8]);
      check("R8 irq after scan", irq, VEC[i][10]);
      if (VEC[i][10]) begin
        bus_write(5'h18, {8'hE0, VEC[i][7:0]});
        check("R4 tx_valid", tx_valid, 1'b1);
        check("R4 tx_data", tx_data, VEC[i][7:0]);
        check("R4 tx_line", tx_line, VEC[i][9:8]);
        bus_read(5'h00, rd); check("R4 ready cleared", rd[15], 1'b0);
      end
    end

    // R5 write with ready clear is ignored
    bus_write(5'h18, 16'h0055);
    check("R5 ignored write", tx_valid, 1'b0);

    // R11 stall while byte is held, R4 hold
    tx_ready = 1'b0;
    bus_write(5'h10, 16'h0001);
    tick();
    bus_read(5'h00, rd); check("R2 wrap to line 0", rd & 16'h8300, 16'h8000);
    bus_write(5'h18, 16'h00A5);
    check("R4 held valid", tx_valid, 1'b1);
    bus_write(5'h10, 16'h0001);
    tick();
    bus_read(5'h00, rd); check("R11 no ready while held", rd[15], 1'b0);
    check("R4 byte held", {tx_valid, tx_line, tx_data}, {1'b1, 2'd0, 8'hA5});
    tx_ready = 1'b1;
    @(negedge clk);
    check("R4 byte taken", tx_valid, 1'b0);
    tick();
    bus_read(5'h00, rd); check("R2 scan resumes", rd, 16'hC020);

    // R6 write mask, clear bit reads 0
    bus_write(5'h00, 16'hFFFF);
    bus_read(5'h00, rd); check("R6 masked status", rd, 16'hC068);

    // R12 line-parameter write has no effect
    bus_write(5'h08, 16'hFFFF);
    bus_read(5'h00, rd); check("R12 status kept", rd, 16'hC068);
    bus_read(5'h10, rd); check("R12 enables kept", rd, 16'h0001);

    // R9 receive handshake
    bus_write(5'h10, 16'h0000);
    rx_valid = 1'b1; rx_char = 8'h3C; rx_line = 2'd2;
    tick();
    bus_read(5'h00, rd); check("R9 receive-done set", rd, 16'h40E8);
    check("R8 irq from receive", irq, 1'b1);
    bus_read(5'h08, rd); check("R9 receive buffer", rd, 16'h823C);
    check("R9 pop pulse", pops, 1);
    bus_read(5'h00, rd); check("R9 receive-done cleared", rd, 16'h4068);
    bus_write(5'h10, 16'h0004);
    tick();
    bus_read(5'h00, rd); check("R9 transmit wins tick", rd, 16'hC268);
    tick();
    bus_read(5'h00, rd); check("R9 receive on next tick", rd, 16'hC2E8);
    rx_valid = 1'b0;

    // R7 scan enable off
    bus_write(5'h00, 16'h4040);
    bus_read(5'h00, rd); check("R7 scan off clears flags", rd, 16'h4240);
    check("R8 irq low", irq, 1'b0);
    bus_write(5'h10, 16'h000F);
    tick();
    bus_read(5'h00, rd); check("R7 tick idle", rd, 16'h4240);
    bus_write(5'h00, 16'h4060);
    tick();
    bus_read(5'h00, rd); check("R2 scan after re-enable", rd, 16'hC360);

    // R10 modem status
    bus_read(5'h18, rd); check("R10 modem word", rd, 16'h0303);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule